// File: doc/BRIEF.md
# Proximity Reader Transmit Framer and Carrier Modulator

This block is the transmit end of a 13.56 MHz proximity card reader. A command source hands it a frame as a stream of bytes. The block makes the RF carrier itself by dividing the system clock by six, so an 81.36 MHz clock gives 13.56 MHz on a single output pin. That pin drives an external switch transistor. A separate enable input turns the carrier on and off.

For each frame the block adds a start pattern. It then sends every byte least significant bit first. A full byte is followed by an odd parity bit. The last byte may be a partial byte of 1 to 7 bits. When the protocol calls for it, the block appends a 16-bit CRC_A. It closes the frame with an end pattern. Each bit slot is coded as modified Miller symbols, and each pause is a full carrier gap (100% ASK). When the last slot has been sent, a one-cycle strobe tells the receive side that a card reply may now arrive.

The state machine has seven states:
- `ST_IDLE` waits for a buffered byte. It moves to `ST_SOC` on the clock where the carrier divider wraps.
- `ST_SOC` sends the start symbol, then moves to `ST_DATA` and loads the first byte.
- `ST_DATA` stays for each further bit of the byte. It then moves to `ST_PAR` after a full byte, or to `ST_EOC0` after a partial byte.
- `ST_PAR` goes back to `ST_DATA` to load the next data byte or a CRC byte. It goes to `ST_EOC0` when nothing is left to send.
- `ST_EOC0` sends a logic-0 symbol and moves to `ST_EOC1`.
- `ST_EOC1` sends one unmodulated slot and moves to `ST_DONE`.
- `ST_DONE` lasts a single clock and returns to `ST_IDLE`.

Top module: `rdr_tx_framer`

## Requirements
- R1: While `carrier_en` is high and no pause is being sent, `carrier_out` is a square wave with a period of `CLK_PER_CARRIER` clocks. It is high for the first half of each period.
- R2: One clock after `carrier_en` is sampled low, `carrier_out` is 0, and it stays 0 while the enable stays low.
- R3: A frame is a series of slots of `CARRIERS_PER_BIT*CLK_PER_CARRIER` clocks each, and each slot holds one symbol:
  - Z has a pause in the first `PAUSE_CARRIERS*CLK_PER_CARRIER` clocks of the slot.
  - X has a pause of the same length starting at the slot midpoint.
  - Y has no pause.
- R3 (coding rules): The first slot is Z. A 1 bit is sent as X. A 0 bit is sent as Y if the previous bit was 1, and as Z if the previous bit was 0 or if it is the first bit after the start slot. Data bits go out least significant bit first.
- R4: After each full byte, the block sends a parity bit that makes the count of ones in the nine bits odd.
- R5: `s_nbits` is the valid-bit count of the byte marked `s_last`. A value of 0 means the byte is full. A value N from 1 to 7 sends only bits 0..N-1 of that byte, with no parity bit after them.
- R6: A CRC_A is appended only when all three of these hold:
  - the frame has at least two bytes;
  - its last byte is full;
  - it is not a select-type command (first byte 0x93, 0x95 or 0x97) whose second byte differs from 0x70.
- R6 (CRC details): The CRC covers all data bytes, uses polynomial x^16+x^12+x^5+1 in reflected form with preset 0x6363, and is sent low byte first. Each CRC byte has its own parity bit.
- R7: After the last data or CRC bit, the block sends a logic-0 symbol by the R3 rule, then one Y slot.
- R8: `tx_done` is high for exactly one clock, in the clock after the final Y slot ends. `busy` is high from the start of the frame until that clock, and drops on the next clock.
- R9: A byte is taken on a clock where `s_valid` and `s_ready` are both high. After the byte marked `s_last` is taken, `s_ready` stays low until the frame is done. The next byte of a frame must be offered before the current byte's last slot ends.
- R10: While the carrier is enabled, `carrier_out` is never low for more than `PAUSE_CARRIERS*CLK_PER_CARRIER + CLK_PER_CARRIER/2 + 1` clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_PER_CARRIER times the carrier frequency |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_en | input | 1 | Turns the RF carrier on |
| s_valid | input | 1 | Frame byte on `s_data` is valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the final byte of the frame |
| s_nbits | input | 3 | Valid bits in the final byte, 0 = full byte |
| s_ready | output | 1 | Block can take a byte |
| busy | output | 1 | A frame is being sent |
| tx_done | output | 1 | One-clock strobe at the end of a frame: the receiver may listen |
| carrier_out | output | 1 | Gated carrier to the external switch |

## Verification
`carrier_out` is registered, so every symbol appears one clock after the slot timer reaches that slot. The bench therefore sets its time origin at the fourth clock of the first long low run. In each slot it looks at a six-clock window at the slot start and another at the slot midpoint, and the expected symbols are worked out from the frame content. The strobe `tx_done` is due exactly one clock before the origin plus the frame's slot count times the slot length. The bench checks it there, and checks that it is low the clock before. `s_ready` is sampled at the falling edge right after the last handshake, and `carrier_out` one full clock after the enable drops.

// File: rtl/rdr_tx_pkg.sv
package rdr_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int NB_W   = $clog2(BYTE_W);
    localparam int BL_W   = NB_W + 1;

    localparam logic [15:0]       CRC_PRESET = 16'h6363;
    localparam logic [BYTE_W-1:0] SEL_LVL1   = 8'h93;
    localparam logic [BYTE_W-1:0] SEL_LVL2   = 8'h95;
    localparam logic [BYTE_W-1:0] SEL_LVL3   = 8'h97;
    localparam logic [BYTE_W-1:0] SEL_FULL   = 8'h70;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOC,
        ST_DATA,
        ST_PAR,
        ST_EOC0,
        ST_EOC1,
        ST_DONE
    } tx_state_e;

    function automatic logic is_select(input logic [BYTE_W-1:0] b);
        return (b == SEL_LVL1) || (b == SEL_LVL2) || (b == SEL_LVL3);
    endfunction

    // Byte-wise step of the reflected CRC_A (x^16+x^12+x^5+1)
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [7:0] ch;
        ch = d ^ c[7:0];
        ch = ch ^ {ch[3:0], 4'b0000};
        return {8'h00, c[15:8]} ^ {ch, 8'h00} ^ {5'b00000, ch, 3'b000} ^ {12'h000, ch[7:4]};
    endfunction

endpackage

// File: rtl/rdr_carrier_div.sv
module rdr_carrier_div #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_hi,
    output logic wrap
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CNT_W'(DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign phase_hi = (cnt < CNT_W'(DIV / 2));
    assign wrap     = (cnt == CNT_W'(DIV - 1));
endmodule

// File: rtl/rdr_slot_timer.sv
module rdr_slot_timer #(
    parameter int SLOT_CLK  = 768,
    parameter int PAUSE_CLK = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic slot_end,
    output logic in_head,
    output logic in_mid
);
    localparam int HALF_CLK = SLOT_CLK / 2;
    localparam int CNT_W    = $clog2(SLOT_CLK);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || slot_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign slot_end = run && (cnt == CNT_W'(SLOT_CLK - 1));
    assign in_head  = (cnt < CNT_W'(PAUSE_CLK));
    assign in_mid   = (cnt >= CNT_W'(HALF_CLK)) && (cnt < CNT_W'(HALF_CLK + PAUSE_CLK));
endmodule

// File: rtl/rdr_crc_a.sv
module rdr_crc_a
    import rdr_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [15:0]       crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= CRC_PRESET;
        else if (clear)
            crc <= CRC_PRESET;
        else if (upd)
            crc <= crc_step(crc, din);
    end
endmodule

// File: rtl/rdr_tx_framer.sv
module rdr_tx_framer
    import rdr_tx_pkg::*;
#(
    parameter int CLK_PER_CARRIER  = 6,
    parameter int CARRIERS_PER_BIT = 128,
    parameter int PAUSE_CARRIERS   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_en,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    input  logic [NB_W-1:0]   s_nbits,
    output logic              s_ready,
    output logic              busy,
    output logic              tx_done,
    output logic              carrier_out
);
    localparam int SLOT_CLK  = CLK_PER_CARRIER * CARRIERS_PER_BIT;
    localparam int PAUSE_CLK = PAUSE_CARRIERS * CLK_PER_CARRIER;

    tx_state_e st, st_nxt;

    // one-byte holding register
    logic              pend_vld, pend_last;
    logic [BYTE_W-1:0] pend_data;
    logic [NB_W-1:0]   pend_nb;
    logic              got_last;

    // byte in flight
    logic [BYTE_W-1:0] shreg;
    logic [BL_W-1:0]   bits_left;
    logic              has_par, par_bit, cur_last, prev_bit;
    logic [1:0]        crc_stage;

    // CRC decision tracking
    logic [1:0] byte_cnt;
    logic       first_sel, sec_full, crc_need;

    logic        div_hi, div_wrap, slot_end, in_head, in_mid, run;
    logic        load_pend, load_crc, cur_bit, pause_now, need_now, sec_now;
    logic [15:0] crc;

    rdr_carrier_div #(.DIV(CLK_PER_CARRIER)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_hi (div_hi),
        .wrap     (div_wrap)
    );

    rdr_slot_timer #(.SLOT_CLK(SLOT_CLK), .PAUSE_CLK(PAUSE_CLK)) i_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .slot_end (slot_end),
        .in_head  (in_head),
        .in_mid   (in_mid)
    );

    rdr_crc_a i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (st == ST_IDLE),
        .upd   (load_pend),
        .din   (pend_data),
        .crc   (crc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (pend_vld && div_wrap) st_nxt = ST_SOC;
            ST_SOC:  if (slot_end) st_nxt = ST_DATA;
            ST_DATA: begin
                if (slot_end && bits_left == BL_W'(1))
                    st_nxt = has_par ? ST_PAR : ST_EOC0;
            end
            ST_PAR: begin
                if (slot_end)
                    st_nxt = (!cur_last || load_crc) ? ST_DATA : ST_EOC0;
            end
            ST_EOC0: if (slot_end) st_nxt = ST_EOC1;
            ST_EOC1: if (slot_end) st_nxt = ST_DONE;
            ST_DONE: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign run       = (st != ST_IDLE) && (st != ST_DONE);
    assign load_pend = slot_end && ((st == ST_SOC) || (st == ST_PAR && !cur_last));
    assign load_crc  = slot_end && (st == ST_PAR) && cur_last &&
                       (((crc_stage == 2'd0) && crc_need) || (crc_stage == 2'd1));
    assign sec_now   = (byte_cnt == 2'd1) ? (pend_data == SEL_FULL) : sec_full;
    assign need_now  = pend_last && (pend_nb == '0) && (byte_cnt != 2'd0) &&
                       !(first_sel && !sec_now);

    assign cur_bit = (st == ST_PAR) ? par_bit : ((st == ST_DATA) ? shreg[0] : 1'b0);

    always_comb begin
        unique case (st)
            ST_SOC:                    pause_now = in_head;
            ST_DATA, ST_PAR, ST_EOC0:  pause_now = cur_bit ? in_mid : (!prev_bit && in_head);
            default:                   pause_now = 1'b0;
        endcase
    end

    // datapath and registered carrier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld    <= 1'b0;
            pend_last   <= 1'b0;
            pend_data   <= '0;
            pend_nb     <= '0;
            got_last    <= 1'b0;
            shreg       <= '0;
            bits_left   <= '0;
            has_par     <= 1'b0;
            par_bit     <= 1'b0;
            cur_last    <= 1'b0;
            prev_bit    <= 1'b0;
            crc_stage   <= 2'd0;
            byte_cnt    <= 2'd0;
            first_sel   <= 1'b0;
            sec_full    <= 1'b0;
            crc_need    <= 1'b0;
            carrier_out <= 1'b0;
        end else begin
            carrier_out <= carrier_en && div_hi && !pause_now;

            if (s_valid && s_ready) begin
                pend_vld  <= 1'b1;
                pend_data <= s_data;
                pend_last <= s_last;
                pend_nb   <= s_nbits;
                if (s_last) got_last <= 1'b1;
            end

            if (load_pend) begin
                pend_vld  <= 1'b0;
                shreg     <= pend_data;
                bits_left <= (pend_nb == '0 || !pend_last) ? BL_W'(BYTE_W) : {1'b0, pend_nb};
                has_par   <= (pend_nb == '0) || !pend_last;
                par_bit   <= ~^pend_data;
                cur_last  <= pend_last;
                crc_need  <= need_now;
                if (byte_cnt == 2'd0) first_sel <= is_select(pend_data);
                if (byte_cnt == 2'd1) sec_full  <= (pend_data == SEL_FULL);
                if (byte_cnt != 2'd2) byte_cnt  <= byte_cnt + 2'd1;
            end else if (load_crc) begin
                shreg     <= (crc_stage == 2'd0) ? crc[7:0] : crc[15:8];
                par_bit   <= (crc_stage == 2'd0) ? ~^crc[7:0] : ~^crc[15:8];
                bits_left <= BL_W'(BYTE_W);
                has_par   <= 1'b1;
                crc_stage <= crc_stage + 2'd1;
            end else if (slot_end && st == ST_DATA) begin
                shreg     <= shreg >> 1;
                bits_left <= bits_left - 1'b1;
            end

            if (slot_end) prev_bit <= (st == ST_SOC) ? 1'b0 : cur_bit;

            if (st == ST_DONE) begin
                got_last  <= 1'b0;
                byte_cnt  <= 2'd0;
                crc_stage <= 2'd0;
                cur_last  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        s_ready = !pend_vld && !got_last;
        busy    = (st != ST_IDLE);
        tx_done = (st == ST_DONE);
    end
endmodule

// File: rtl/rdr_tx_chk.sv
module rdr_tx_chk #(
    parameter int CLK_PER_CARRIER = 6,
    parameter int PAUSE_CARRIERS  = 40
) (
    input logic clk,
    input logic rst_n,
    input logic carrier_en,
    input logic carrier_out,
    input logic busy,
    input logic tx_done,
    input logic s_ready
);
    localparam int LOW_MAX = PAUSE_CARRIERS * CLK_PER_CARRIER + CLK_PER_CARRIER / 2 + 1;
    localparam int RUN_W   = $clog2(LOW_MAX + 2) + 1;

    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= '0;
        else if (!carrier_en || carrier_out)
            low_run <= '0;
        else if (low_run != {RUN_W{1'b1}})
            low_run <= low_run + 1'b1;
    end

    assert_carrier_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_en |=> !carrier_out);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx_done));

    assert_no_take_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !s_ready);

    assert_pause_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= RUN_W'(LOW_MAX));
endmodule

bind rdr_tx_framer rdr_tx_chk #(
    .CLK_PER_CARRIER (CLK_PER_CARRIER),
    .PAUSE_CARRIERS  (PAUSE_CARRIERS)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .carrier_en  (carrier_en),
    .carrier_out (carrier_out),
    .busy        (busy),
    .tx_done     (tx_done),
    .s_ready     (s_ready)
);

// File: tb/test_rdr_tx_framer.sv
`timescale 1ns/1ps
module test_rdr_tx_framer;
    localparam int CPC = 6;
    localparam int CPB = 8;
    localparam int PC  = 3;
    localparam int S   = CPB * CPC;
    localparam int H   = S / 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, carrier_en, s_valid, s_last;
    logic [7:0] s_data;
    logic [2:0] s_nbits;
    logic       s_ready, busy, tx_done, carrier_out;

    rdr_tx_framer #(.CLK_PER_CARRIER(CPC), .CARRIERS_PER_BIT(CPB), .PAUSE_CARRIERS(PC)) i_rdr_tx_framer (
        .clk(clk), .rst_n(rst_n), .carrier_en(carrier_en), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .s_nbits(s_nbits), .s_ready(s_ready), .busy(busy), .tx_done(tx_done),
        .carrier_out(carrier_out)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] fr_data [8];
    int fr_len;
    int fr_nb;
    int exp_sym [100];
    int exp_n;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // symbols: 0 = X, 1 = Y, 2 = Z, 3 = malformed
    function automatic void build_expected();
        int bits [120];
        int nb = 0;
        logic [15:0] crc = 16'h6363;
        bit need;
        int prev;
        for (int i = 0; i < fr_len; i++) begin
            int n = (i == fr_len - 1 && fr_nb != 0) ? fr_nb : 8;
            for (int j = 0; j < n; j++) bits[nb++] = fr_data[i][j];
            if (n == 8) bits[nb++] = ~^fr_data[i];
            for (int j = 0; j < 8; j++) begin
                bit fb = crc[0] ^ fr_data[i][j];
                crc = crc >> 1;
                if (fb) crc = crc ^ 16'h8408;
            end
        end
        need = (fr_len >= 2) && (fr_nb == 0) &&
               !((fr_data[0] == 8'h93 || fr_data[0] == 8'h95 || fr_data[0] == 8'h97) && fr_data[1] != 8'h70);
        if (need) begin
            for (int j = 0; j < 8; j++) bits[nb++] = crc[j];
            bits[nb++] = ~^crc[7:0];
            for (int j = 0; j < 8; j++) bits[nb++] = crc[8+j];
            bits[nb++] = ~^crc[15:8];
        end
        exp_sym[0] = 2;
        exp_n = 1;
        prev = 0;
        for (int i = 0; i < nb; i++) begin
            exp_sym[exp_n++] = bits[i] ? 0 : (prev ? 1 : 2);
            prev = bits[i];
        end
        exp_sym[exp_n++] = prev ? 1 : 2;
        exp_sym[exp_n++] = 1;
    endfunction

    task automatic run_frame(input string tag);
        bit eh [100];
        bit mh [100];
        bit started = 0;
        bit d_at = 0, d_pre = 1;
        build_expected();
        for (int k = 0; k < 100; k++) begin eh[k] = 0; mh[k] = 0; end
        fork
            begin
                for (int i = 0; i < fr_len; i++) begin
                    @(negedge clk);
                    s_valid = 1'b1;
                    s_data  = fr_data[i];
                    s_last  = (i == fr_len - 1);
                    s_nbits = (i == fr_len - 1) ? 3'(fr_nb) : 3'd0;
                    while (!s_ready) @(negedge clk);
                    @(posedge clk);
                end
                @(negedge clk);
                s_valid = 1'b0;
                s_last  = 1'b0;
                check(!s_ready, "R9 ready after last byte", int'(s_ready), 0);
            end
            begin
                int run = 0;
                int waited = 0;
                while (!started && waited < 6000) begin
                    @(negedge clk);
                    waited++;
                    if (!carrier_out) run++; else run = 0;
                    if (run == 4) started = 1;
                end
                if (started) begin
                    for (int t = 0; t < (exp_n + 1) * S; t++) begin
                        int k = t / S;
                        int r = t % S;
                        if (t > 0) @(negedge clk);
                        if (r < 6 && carrier_out) eh[k] = 1;
                        if (r >= H && r < H + 6 && carrier_out) mh[k] = 1;
                        if (t == exp_n * S - 1) d_at = tx_done;
                        if (t == exp_n * S - 2) d_pre = tx_done;
                    end
                end
            end
        join
        if (!started) begin
            check(0, {tag, " no frame start"}, 0, 1);
        end else begin
            int bad = 0, fa = 0, fe = 0;
            for (int k = 0; k <= exp_n; k++) begin
                int o = (eh[k] && mh[k]) ? 1 : (eh[k] ? 0 : (mh[k] ? 2 : 3));
                int e = (k < exp_n) ? exp_sym[k] : 1;
                if (o != e && bad == 0) begin fa = (k << 4) | o; fe = (k << 4) | e; end
                if (o != e) bad++;
            end
            check(bad == 0, {tag, " symbol slot/kind"}, fa, fe);
            check(d_at && !d_pre, "R8 tx_done timing", {d_pre, d_at}, 1);
        end
        while (busy) @(negedge clk);
        repeat (S) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ones;
        bit v [12];
        bit ok;
        bit offok;
        void'($urandom(32'h5EED_1443));
        rst_n = 0; carrier_en = 0; s_valid = 0; s_data = 0; s_last = 0; s_nbits = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(carrier_out == 0, "R2 reset carrier", int'(carrier_out), 0);
        check(busy == 0, "R8 reset busy", int'(busy), 0);
        check(tx_done == 0, "R8 reset done", int'(tx_done), 0);
        check(s_ready == 1, "R9 reset ready", int'(s_ready), 1);

        carrier_en = 1;
        repeat (10) @(negedge clk);
        ones = 0;
        for (int i = 0; i < 12; i++) begin
            v[i] = carrier_out;
            ones += int'(carrier_out);
            @(negedge clk);
        end
        ok = 1;
        for (int i = 0; i < 9; i++) if (v[i] == v[i+3]) ok = 0;
        check(ones == 6, "R1 carrier duty", ones, 6);
        check(ok, "R1 carrier period", int'(ok), 1);

        carrier_en = 0;
        @(negedge clk);
        offok = 1;
        for (int i = 0; i < 24; i++) begin
            if (carrier_out) offok = 0;
            @(negedge clk);
        end
        check(offok, "R2 carrier held off", int'(offok), 1);
        carrier_en = 1;
        repeat (12) @(negedge clk);

        fr_len = 1; fr_nb = 7; fr_data[0] = 8'h26;
        run_frame("R5 short 7-bit frame");
        fr_len = 2; fr_nb = 0; fr_data[0] = 8'h93; fr_data[1] = 8'h20;
        run_frame("R6 select without CRC");
        fr_len = 2; fr_nb = 0; fr_data[0] = 8'h60; fr_data[1] = 8'h07;
        run_frame("R6 two-byte CRC frame");
        fr_len = 3; fr_nb = 2; fr_data[0] = 8'h93; fr_data[1] = 8'h22; fr_data[2] = 8'h03;
        run_frame("R5 partial last byte");
        fr_len = 1; fr_nb = 0; fr_data[0] = 8'h00;
        run_frame("R4 R7 zero byte with parity");
        fr_len = 7; fr_nb = 0;
        fr_data[0] = 8'h93; fr_data[1] = 8'h70; fr_data[2] = 8'h4B; fr_data[3] = 8'hBE;
        fr_data[4] = 8'hDE; fr_data[5] = 8'h79; fr_data[6] = 8'h52;
        run_frame("R6 full select with CRC");

        for (int n = 0; n < 14; n++) begin
            fr_len = 1 + $urandom_range(4);
            for (int i = 0; i < fr_len; i++) fr_data[i] = 8'($urandom);
            if ($urandom_range(3) == 0) fr_data[0] = 8'h93;
            if (fr_len >= 2 && $urandom_range(1) == 0) fr_data[1] = 8'h70;
            fr_nb = ($urandom_range(1) == 0) ? 0 : $urandom_range(7, 1);
            run_frame("R3 R4 R5 R6 R7 random frame");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule